// File: doc/BRIEF.md
# Clocked Phase-Frequency Detector with Programmable Overlap Pulse

This block sits between the two dividers of a synthesizer loop and the charge pump. It samples a one-cycle divided reference pulse and a one-cycle divided oscillator pulse on a fast clock. From them it issues an up command and a down command that follow both the frequency error and the phase error.

Whenever both commands are active together, they stay active for a fixed overlap interval before both release. Even at zero phase error, both pump commands therefore produce a measurable pulse, which removes the dead zone near lock. The overlap interval can be set to one of four lengths. A polarity control exchanges the two commands for loops with an inverting oscillator. A standby control silences the block.

A lock flag is derived from the overlap pulse. It is raised after a run of comparisons whose total active span equals the bare overlap interval. It is dropped the moment any span grows wider than that interval.

Top module: `pfd_abl`

## Requirements
- R1: A rising edge on `ref_pulse` sets the internal up state and a rising edge on `vco_pulse` sets the internal down state. Each output is registered, so an edge driven in the cycle before clock edge k first shows on the pump output after clock edge k+1.
- R2: Once both internal states are set, both stay set for exactly L clock cycles and then clear together. With a lead of d cycles, the leading output is high for d+L cycles and the lagging output for L cycles.
- R3: L equals ABL_BASE shifted left by `abl_sel`. At the default ABL_BASE of 2, the values of `abl_sel` from 0 to 3 give 2, 4, 8 and 16 cycles.
- R4: Further edges on one input while its state is already set, and before the other input's edge, have no effect. The leading output stays high and the other output stays low until the other edge arrives.
- R5: With `pol_swap` at 1, `pump_up` carries the down state and `pump_dn` carries the up state. Widths and lock are unchanged.
- R6: While `standby` is 1, `pump_up`, `pump_dn` and `lock` are forced low from the next cycle on. All pending state and the lock streak are cleared, so the first comparison after release starts clean.
- R7: `lock` rises one cycle after the end of the fourth consecutive comparison whose active span (up or down set) equals exactly L cycles. It stays high while such comparisons continue.
- R8: As soon as an active span exceeds L cycles, `lock` falls and the streak restarts. This also happens while one input is missing altogether.
- R9: While `rst` (synchronous, active high) is asserted, all outputs and all state are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse | input | 1 | Divided reference pulse, synchronous to clk |
| vco_pulse | input | 1 | Divided oscillator pulse, synchronous to clk |
| abl_sel | input | 2 | Overlap interval select, L = ABL_BASE << abl_sel |
| pol_swap | input | 1 | 1 exchanges the up and down outputs |
| standby | input | 1 | 1 silences and clears the detector |
| pump_up | output | 1 | Registered up command |
| pump_dn | output | 1 | Registered down command |
| lock | output | 1 | Lock flag from overlap-span tracking |

## Verification
The overlap-length and wide-span properties measure their windows against the L taken from the present `abl_sel`. They therefore assume that `abl_sel` changes only while both pump outputs are idle. They also assume that the two inputs are one-cycle pulses spaced far apart relative to L, so that no new edge lands in the cycle in which the overlap clears. The stimulus respects both: it changes the select only between comparison windows of 64 cycles that outlast every pulse. It places each edge at a fixed offset early in its window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Overlap interval in fast-clock cycles for a given select value.
  function automatic int unsigned abl_cycles(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

  // Counter width that holds the largest overlap plus one.
  function automatic int unsigned abl_cnt_w(input int unsigned base);
    return $clog2(base * 8 + 2);
  endfunction

endpackage

// File: rtl/pfd_edge.sv
module pfd_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= din[g];
      end
      assign rise[g] = din[g] & ~prev_q;
    end
  endgenerate

endmodule

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          ref_rise,
  input  logic          vco_rise,
  input  logic [CW-1:0] len,
  output logic          up_q,
  output logic          dn_q,
  output logic          clr
);

  logic [CW-1:0] ov_cnt;
  logic          both;

  assign both = up_q & dn_q;
  assign clr  = both & (ov_cnt == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      ov_cnt <= '0;
    end else begin
      up_q   <= (up_q & ~clr) | ref_rise;
      dn_q   <= (dn_q & ~clr) | vco_rise;
      ov_cnt <= (both & ~clr) ? ov_cnt + 1'b1 : '0;
    end
  end

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock #(
  parameter int CW   = 5,
  parameter int RUNS = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          active,
  input  logic          clr,
  input  logic [CW-1:0] len,
  output logic          lock_q
);

  localparam int SW = $clog2(RUNS + 1);

  logic [CW-1:0] span;
  logic [SW-1:0] streak;
  logic          too_wide;
  logic          clean;

  assign too_wide = active & (span == len);
  assign clean    = clr & (span == len - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      span   <= '0;
      streak <= '0;
      lock_q <= 1'b0;
    end else begin
      if (!active)          span <= '0;
      else if (span != len) span <= span + 1'b1;

      if (too_wide) begin
        streak <= '0;
        lock_q <= 1'b0;
      end else if (clean) begin
        if (streak != SW'(RUNS)) streak <= streak + 1'b1;
        if (streak >= SW'(RUNS - 1)) lock_q <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/pfd_abl.sv
module pfd_abl #(
  parameter int ABL_BASE  = 2,
  parameter int LOCK_RUNS = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_pulse,
  input  logic       vco_pulse,
  input  logic [1:0] abl_sel,
  input  logic       pol_swap,
  input  logic       standby,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       lock
);

  import pfd_pkg::*;

  localparam int CW = abl_cnt_w(ABL_BASE);

  logic [1:0]    rise;
  logic [CW-1:0] len;
  logic          up_q, dn_q, clr;

  assign len = CW'(abl_cycles(ABL_BASE, abl_sel));

  pfd_edge #(.N(2)) u_edge (
    .clk  (clk),
    .rst  (rst),
    .din  ({vco_pulse, ref_pulse}),
    .rise (rise)
  );

  pfd_core #(.CW(CW)) u_core (
    .clk      (clk),
    .rst      (rst),
    .hold     (standby),
    .ref_rise (rise[0]),
    .vco_rise (rise[1]),
    .len      (len),
    .up_q     (up_q),
    .dn_q     (dn_q),
    .clr      (clr)
  );

  pfd_lock #(.CW(CW), .RUNS(LOCK_RUNS)) u_lock (
    .clk    (clk),
    .rst    (rst),
    .hold   (standby),
    .active (up_q | dn_q),
    .clr    (clr),
    .len    (len),
    .lock_q (lock)
  );

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      pump_up <= 1'b0;
      pump_dn <= 1'b0;
    end else begin
      pump_up <= pol_swap ? dn_q : up_q;
      pump_dn <= pol_swap ? up_q : dn_q;
    end
  end

endmodule

// File: rtl/pfd_abl_chk.sv
module pfd_abl_chk #(
  parameter int ABL_BASE = 2
) (
  input logic       clk,
  input logic       rst,
  input logic       standby,
  input logic [1:0] abl_sel,
  input logic       pump_up,
  input logic       pump_dn,
  input logic       lock
);

  import pfd_pkg::*;

  localparam int CW = abl_cnt_w(ABL_BASE) + 1;

  logic [CW-1:0] len;
  logic [CW-1:0] ov_c;
  logic [CW-1:0] span_c;

  assign len = CW'(abl_cycles(ABL_BASE, abl_sel));

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      ov_c   <= '0;
      span_c <= '0;
    end else begin
      if (!(pump_up && pump_dn))      ov_c <= '0;
      else if (ov_c != {CW{1'b1}})    ov_c <= ov_c + 1'b1;
      if (!(pump_up || pump_dn))      span_c <= '0;
      else if (span_c != {CW{1'b1}})  span_c <= span_c + 1'b1;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!pump_up && !pump_dn && !lock)); // R9

  AST_STBY_QUIET: assert property (@(posedge clk) disable iff (rst)
    standby |=> (!pump_up && !pump_dn && !lock)); // R6

  AST_OVERLAP_BOUND: assert property (@(posedge clk) disable iff (rst || standby)
    (pump_up && pump_dn) |-> (ov_c < len)); // R2

  AST_WIDE_UNLOCK: assert property (@(posedge clk) disable iff (rst || standby)
    ((pump_up || pump_dn) && span_c >= len) |-> !lock); // R8

  AST_LOCK_ON_CLEAN: assert property (@(posedge clk) disable iff (rst || standby)
    $rose(lock) |-> (pump_up && pump_dn)); // R7

endmodule

bind pfd_abl pfd_abl_chk #(.ABL_BASE(ABL_BASE)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .standby (standby),
  .abl_sel (abl_sel),
  .pump_up (pump_up),
  .pump_dn (pump_dn),
  .lock    (lock)
);

// File: tb/pfd_abl_tb.sv
module pfd_abl_tb;

  localparam int BASE = 2;
  localparam int W    = 64;
  localparam int RUNS = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_pulse = 1'b0;
  logic       vco_pulse = 1'b0;
  logic [1:0] abl_sel = 2'd0;
  logic       pol_swap = 1'b0;
  logic       standby = 1'b0;
  logic       pump_up, pump_dn, lock;

  int checks = 0;
  int fails  = 0;
  int streak = 0;
  int uc, dc, uf, df;

  always #2.5 clk = ~clk;

  pfd_abl #(.ABL_BASE(BASE), .LOCK_RUNS(RUNS)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .ref_pulse (ref_pulse),
    .vco_pulse (vco_pulse),
    .abl_sel   (abl_sel),
    .pol_swap  (pol_swap),
    .standby   (standby),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .lock      (lock)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One comparison window; -1 means no pulse at that slot.
  task automatic window(input int a, input int a2, input int b, input int b2,
                        output int ucnt, output int dcnt, output int ufirst, output int dfirst);
    ucnt = 0; dcnt = 0; ufirst = -1; dfirst = -1;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (pump_up === 1'b1) begin ucnt++; if (ufirst < 0) ufirst = i; end
      if (pump_dn === 1'b1) begin dcnt++; if (dfirst < 0) dfirst = i; end
      ref_pulse = (i == a) || (i == a2);
      vco_pulse = (i == b) || (i == b2);
    end
  endtask

  // Offset d = vco edge minus ref edge; updates the lock model.
  task automatic compare(input int d, input string req);
    int a, b, len, eu, ed, t;
    len = BASE << abl_sel;
    a = (d < 0) ? 4 - d : 4;
    b = a + d;
    window(a, -1, b, -1, uc, dc, uf, df);
    eu = (d >= 0) ? d + len : len;
    ed = (d >= 0) ? len : len - d;
    if (pol_swap) begin t = eu; eu = ed; ed = t; end
    chk(req, "up width", uc, eu);
    chk(req, "dn width", dc, ed);
    streak = (d == 0) ? streak + 1 : 0;
    chk("R7 R8", "lock", lock, (streak >= RUNS) ? 1 : 0);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", "up in reset", pump_up, 0);
    chk("R9", "dn in reset", pump_dn, 0);
    chk("R9", "lock in reset", lock, 0);
    @(negedge clk); rst = 1'b0;

    // R1 latency: ref at slot 4 first seen at sample 6, vco at slot 7 at 9
    window(4, -1, 7, -1, uc, dc, uf, df);
    chk("R1", "up first sample", uf, 6);
    chk("R1", "dn first sample", df, 9);
    streak = 0;

    // R2 R3 R5 sweep over every select, both polarities, offsets -5..5
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 2; p++) begin
        abl_sel = 2'(s); pol_swap = p[0];
        for (int d = -5; d <= 5; d++) compare(d, p ? "R2 R3 R5" : "R2 R3");
      end
    end
    pol_swap = 1'b0;

    // R7: four clean comparisons raise lock; R8: a lead drops it
    for (int s = 1; s < 3; s++) begin
      abl_sel = 2'(s);
      for (int k = 0; k < 5; k++) compare(0, "R7");
      compare(2, "R8");
    end

    // R4: second ref edge before the vco edge
    abl_sel = 2'd1;
    window(2, 8, 14, -1, uc, dc, uf, df);
    chk("R4", "up width double ref", uc, 12 + 4);
    chk("R4", "dn width double ref", dc, 4);
    window(14, -1, 2, 8, uc, dc, uf, df);
    chk("R4", "up width double vco", uc, 4);
    chk("R4", "dn width double vco", dc, 12 + 4);
    streak = 0;

    // R8: missing vco drops an established lock
    for (int k = 0; k < 4; k++) compare(0, "R7");
    chk("R7", "lock before missing vco", lock, 1);
    window(3, -1, -1, -1, uc, dc, uf, df);
    chk("R4", "up stuck without vco", uc, W - 5);
    chk("R4", "dn idle without vco", dc, 0);
    chk("R8", "lock with missing vco", lock, 0);
    window(-1, -1, 0, -1, uc, dc, uf, df);
    streak = 0;
    compare(0, "R2");

    // R6: standby silences outputs and lock
    for (int k = 0; k < 3; k++) compare(0, "R7");
    chk("R7", "lock before standby", lock, 1);
    standby = 1'b1;
    window(2, -1, 5, -1, uc, dc, uf, df);
    chk("R6", "up in standby", uc, 0);
    chk("R6", "dn in standby", dc, 0);
    chk("R6", "lock in standby", lock, 0);
    standby = 1'b0;
    streak = 0;

    // R6: standby in the middle of a pending up clears it
    window(3, -1, -1, -1, uc, dc, uf, df);
    @(negedge clk); standby = 1'b1;
    repeat (3) @(negedge clk);
    standby = 1'b0;
    compare(0, "R6");

    summary();
    $finish;
  end

endmodule